// File: doc/BRIEF.md
# Ternary Test-Set Compatibility Checker

This block decides whether a chosen group of input columns of a partially specified test set can share one source of stimulus. The test set is streamed in one vector per beat. Every column position of a vector holds a three-valued code: logic 0, logic 1, or don't-care. While the rows stream past, the block evaluates each one against the loaded relation. It keeps a sticky conflict flag and the index of the first row that broke the relation. The relation is one of three kinds. Direct: all selected columns must agree wherever they are specified. Inverse: two columns must differ wherever both are specified. Gate: a target column must be reachable as the output of a two-input gate fed by two source columns.

A configuration load picks the relation, the columns and, in gate mode, one of ten two-input functions. Loads that name an unusable relation are refused. An accepted load clears the previous verdict and opens a new stream. A strobe on the last row closes the stream. A one-cycle result pulse follows in the next cycle, and the verdict stays visible until the next accepted load.

A small state machine sequences the stream. Its states are ST_IDLE, ST_READY, ST_RUN and ST_DONE.

- ST_IDLE: no stream is open and row beats are ignored. An accepted load moves it to ST_READY.
- ST_READY: a stream is open with no rows yet. A row beat with the last strobe moves it to ST_DONE. A row beat without the strobe moves it to ST_RUN. An accepted load keeps it in ST_READY.
- ST_RUN: rows are arriving. Its transitions are the same as those of ST_READY.
- ST_DONE: lasts one cycle, during which the result pulse is high. It returns to ST_IDLE, or to ST_READY on an accepted load.

Top module: `ternary_compat_checker`

## Requirements
- R1: Each column code is two bits: 2'b00 is logic 0, 2'b01 is logic 1, and any code with bit 1 set (2'b1x) is don't-care. A don't-care entry never makes a row conflict in any relation.
- R2: Direct relation (mode 2'b00, columns chosen by the mask, bit i = column i): a row conflicts when at least one masked column holds 0 and at least one masked column holds 1.
- R3: Inverse relation (mode 2'b01, columns A and B): a row conflicts when both columns are specified and hold equal values.
- R4: Gate relation (mode 2'b10, sources A and B, target C): a row conflicts when the target is specified and no completion of the don't-care source entries makes the gate output equal the target. Function codes are: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR, 6 A AND NOT B, 7 NOT A AND B, 8 A OR NOT B, 9 NOT A OR B.
- R5: A load is refused and has no effect in any of these cases: mode is 2'b11; the mode is gate and the function code is 10 or above; a column index used by the mode is not below NUM_COLS (inverse uses A and B, gate uses A, B and C, direct uses none). A refused load leaves the verdict, the row count and the stream state untouched.
- R6: An accepted load clears the conflict flag and the first-conflict index to 0, restarts row numbering at 0 and opens a stream. It takes priority over a row beat in the same cycle, and that row is dropped.
- R7: The conflict flag is sticky until the next accepted load. The first-conflict index is the 0-based number of the first conflicting row accepted since the load, and later conflicts never change it. The index reads 0 while no conflict has been seen.
- R8: A row beat carrying the last strobe produces a result pulse of exactly one cycle in the following cycle. After that beat, row beats are ignored until an accepted load.
- R9: After reset, all outputs read 0 and row beats are ignored until the first accepted load.
- R10: Row numbering saturates at 2^ROW_W-1. Rows from that point on all carry that index.
- R11: The conflict flag and the index reflect a row in the cycle after its beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_mode | input | 2 | Relation: 00 direct, 01 inverse, 10 gate, 11 refused |
| cfg_mask | input | NUM_COLS | Columns joined in the direct relation |
| cfg_col_a | input | COL_IDX_W | First column (inverse) or first gate source |
| cfg_col_b | input | COL_IDX_W | Second column (inverse) or second gate source |
| cfg_col_c | input | COL_IDX_W | Gate target column |
| cfg_func | input | 4 | Gate function code 0..9 |
| row_valid | input | 1 | Row beat |
| row_last | input | 1 | Marks the final row of the stream |
| row_data | input | 2*NUM_COLS | Ternary codes, column i in bits [2i+1:2i] |
| res_valid | output | 1 | One-cycle result pulse |
| conflict | output | 1 | Sticky conflict flag |
| first_row | output | ROW_W | Index of the first conflicting row |

## Verification
The bench builds the block with NUM_COLS = 6 and ROW_W = 4. With six columns, a 3-bit column index can name 6 and 7, so refused loads caused by out-of-range columns can be reached. With a 4-bit row index, the counter saturates after 16 rows, so a conflict on row 18 shows the clamped index within a short stream. Every gate function is swept with random ternary rows, including both don't-care encodings. A behavioural model is compared on every cycle, and the worked matrix cases carry hand-computed verdicts.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        REL_DIRECT  = 2'b00,
        REL_INVERSE = 2'b01,
        REL_GATE    = 2'b10,
        REL_RSVD    = 2'b11
    } relation_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef logic [1:0] tern_t;

    localparam tern_t TERN_ZERO = 2'b00;
    localparam tern_t TERN_ONE  = 2'b01;
    localparam tern_t TERN_DC   = 2'b10;

    localparam int GATE_FUNCS = 10;

    function automatic logic tern_is_dc(input tern_t t);
        return t[1];
    endfunction

    // truth table indexed by {a,b}: bit k is the output for a=k[1], b=k[0]
    function automatic logic [3:0] gate_table(input logic [3:0] code);
        logic [3:0] tt;
        unique case (code)
            4'd0:    tt = 4'b1000;  // AND
            4'd1:    tt = 4'b0111;  // NAND
            4'd2:    tt = 4'b1110;  // OR
            4'd3:    tt = 4'b0001;  // NOR
            4'd4:    tt = 4'b0110;  // XOR
            4'd5:    tt = 4'b1001;  // XNOR
            4'd6:    tt = 4'b0100;  // A and not B
            4'd7:    tt = 4'b0010;  // not A and B
            4'd8:    tt = 4'b1101;  // A or not B
            4'd9:    tt = 4'b1011;  // not A or B
            default: tt = 4'b0000;
        endcase
        return tt;
    endfunction

endpackage

// File: rtl/tcc_cfg_reg.sv
module tcc_cfg_reg
    import tcc_pkg::*;
#(
    parameter int NUM_COLS  = 16,
    parameter int COL_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [1:0]           mode_in,
    input  logic [NUM_COLS-1:0]  mask_in,
    input  logic [COL_IDX_W-1:0] col_a_in,
    input  logic [COL_IDX_W-1:0] col_b_in,
    input  logic [COL_IDX_W-1:0] col_c_in,
    input  logic [3:0]           func_in,
    output logic                 take,
    output relation_e            mode_q,
    output logic [NUM_COLS-1:0]  mask_q,
    output logic [COL_IDX_W-1:0] col_a_q,
    output logic [COL_IDX_W-1:0] col_b_q,
    output logic [COL_IDX_W-1:0] col_c_q,
    output logic [3:0]           table_q
);

    logic a_ok, b_ok, c_ok, func_ok, fields_ok;

    always_comb begin
        a_ok    = (int'(col_a_in) < NUM_COLS);
        b_ok    = (int'(col_b_in) < NUM_COLS);
        c_ok    = (int'(col_c_in) < NUM_COLS);
        func_ok = (int'(func_in) < GATE_FUNCS);
        unique case (relation_e'(mode_in))
            REL_DIRECT:  fields_ok = 1'b1;
            REL_INVERSE: fields_ok = a_ok && b_ok;
            REL_GATE:    fields_ok = a_ok && b_ok && c_ok && func_ok;
            default:     fields_ok = 1'b0;
        endcase
    end

    assign take = load && fields_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= REL_DIRECT;
            mask_q  <= '0;
            col_a_q <= '0;
            col_b_q <= '0;
            col_c_q <= '0;
            table_q <= '0;
        end else if (take) begin
            mode_q  <= relation_e'(mode_in);
            mask_q  <= mask_in;
            col_a_q <= col_a_in;
            col_b_q <= col_b_in;
            col_c_q <= col_c_in;
            table_q <= gate_table(func_in);
        end
    end

endmodule

// File: rtl/tcc_gate_eval.sv
module tcc_gate_eval
    import tcc_pkg::*;
(
    input  tern_t      src_a,
    input  tern_t      src_b,
    input  tern_t      target,
    input  logic [3:0] table_in,
    output logic       clash
);

    logic [3:0] reachable;

    for (genvar k = 0; k < 4; k++) begin : g_combo
        logic a_fits, b_fits;
        assign a_fits       = tern_is_dc(src_a) || (src_a[0] == k[1]);
        assign b_fits       = tern_is_dc(src_b) || (src_b[0] == k[0]);
        assign reachable[k] = a_fits && b_fits && (table_in[k] == target[0]);
    end

    assign clash = !tern_is_dc(target) && (reachable == 4'b0000);

endmodule

// File: rtl/tcc_row_eval.sv
module tcc_row_eval
    import tcc_pkg::*;
#(
    parameter int NUM_COLS  = 16,
    parameter int COL_IDX_W = 4
) (
    input  logic [2*NUM_COLS-1:0] row_data,
    input  relation_e             mode,
    input  logic [NUM_COLS-1:0]   mask,
    input  logic [COL_IDX_W-1:0]  col_a,
    input  logic [COL_IDX_W-1:0]  col_b,
    input  logic [COL_IDX_W-1:0]  col_c,
    input  logic [3:0]            table_in,
    output logic                  row_clash
);

    localparam int SLOTS = 1 << COL_IDX_W;

    tern_t                codes [SLOTS];
    logic [NUM_COLS-1:0]  has_zero;
    logic [NUM_COLS-1:0]  has_one;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_COLS) begin : g_real
            assign codes[i]    = row_data[2*i +: 2];
            assign has_zero[i] = mask[i] && (codes[i] == TERN_ZERO);
            assign has_one[i]  = mask[i] && (codes[i] == TERN_ONE);
        end else begin : g_pad
            assign codes[i] = TERN_DC;
        end
    end

    tern_t va, vb, vc;
    assign va = codes[col_a];
    assign vb = codes[col_b];
    assign vc = codes[col_c];

    logic direct_clash, inverse_clash, gate_clash;

    assign direct_clash  = (|has_zero) && (|has_one);
    assign inverse_clash = !tern_is_dc(va) && !tern_is_dc(vb) && (va[0] == vb[0]);

    tcc_gate_eval u_gate (
        .src_a    (va),
        .src_b    (vb),
        .target   (vc),
        .table_in (table_in),
        .clash    (gate_clash)
    );

    always_comb begin
        unique case (mode)
            REL_DIRECT:  row_clash = direct_clash;
            REL_INVERSE: row_clash = inverse_clash;
            REL_GATE:    row_clash = gate_clash;
            default:     row_clash = 1'b0;
        endcase
    end

endmodule

// File: rtl/tcc_seq_ctrl.sv
module tcc_seq_ctrl
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_take,
    input  logic row_valid,
    input  logic row_last,
    output logic row_take,
    output logic done_pulse
);

    seq_state_e state_q, state_d;
    logic       open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        open     = (state_q == ST_READY) || (state_q == ST_RUN);
        row_take = open && row_valid && !cfg_take;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_take) state_d = ST_READY;
            end
            ST_READY, ST_RUN: begin
                if (cfg_take)                  state_d = ST_READY;
                else if (row_take && row_last) state_d = ST_DONE;
                else if (row_take)             state_d = ST_RUN;
            end
            ST_DONE: begin
                state_d = cfg_take ? ST_READY : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        done_pulse = (state_q == ST_DONE);
    end

endmodule

// File: rtl/ternary_compat_checker.sv
module ternary_compat_checker
    import tcc_pkg::*;
#(
    parameter int NUM_COLS  = 16,
    parameter int ROW_W     = 16,
    parameter int COL_IDX_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [1:0]            cfg_mode,
    input  logic [NUM_COLS-1:0]   cfg_mask,
    input  logic [COL_IDX_W-1:0]  cfg_col_a,
    input  logic [COL_IDX_W-1:0]  cfg_col_b,
    input  logic [COL_IDX_W-1:0]  cfg_col_c,
    input  logic [3:0]            cfg_func,
    input  logic                  row_valid,
    input  logic                  row_last,
    input  logic [2*NUM_COLS-1:0] row_data,
    output logic                  res_valid,
    output logic                  conflict,
    output logic [ROW_W-1:0]      first_row
);

    localparam logic [ROW_W-1:0] ROW_MAX = '1;

    logic                 cfg_take;
    logic                 row_take;
    logic                 row_clash;
    relation_e            mode_q;
    logic [NUM_COLS-1:0]  mask_q;
    logic [COL_IDX_W-1:0] col_a_q, col_b_q, col_c_q;
    logic [3:0]           table_q;
    logic [ROW_W-1:0]     row_idx_q;

    tcc_cfg_reg #(.NUM_COLS(NUM_COLS), .COL_IDX_W(COL_IDX_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .mode_in  (cfg_mode),
        .mask_in  (cfg_mask),
        .col_a_in (cfg_col_a),
        .col_b_in (cfg_col_b),
        .col_c_in (cfg_col_c),
        .func_in  (cfg_func),
        .take     (cfg_take),
        .mode_q   (mode_q),
        .mask_q   (mask_q),
        .col_a_q  (col_a_q),
        .col_b_q  (col_b_q),
        .col_c_q  (col_c_q),
        .table_q  (table_q)
    );

    tcc_row_eval #(.NUM_COLS(NUM_COLS), .COL_IDX_W(COL_IDX_W)) u_eval (
        .row_data  (row_data),
        .mode      (mode_q),
        .mask      (mask_q),
        .col_a     (col_a_q),
        .col_b     (col_b_q),
        .col_c     (col_c_q),
        .table_in  (table_q),
        .row_clash (row_clash)
    );

    tcc_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_take   (cfg_take),
        .row_valid  (row_valid),
        .row_last   (row_last),
        .row_take   (row_take),
        .done_pulse (res_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx_q <= '0;
        end else if (cfg_take) begin
            row_idx_q <= '0;
        end else if (row_take && (row_idx_q != ROW_MAX)) begin
            row_idx_q <= row_idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conflict  <= 1'b0;
            first_row <= '0;
        end else if (cfg_take) begin
            conflict  <= 1'b0;
            first_row <= '0;
        end else if (row_take && row_clash && !conflict) begin
            conflict  <= 1'b1;
            first_row <= row_idx_q;
        end
    end

endmodule

// File: rtl/tcc_sva.sv
module tcc_sva #(
    parameter int ROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_take,
    input logic             row_take,
    input logic             row_last,
    input logic             res_valid,
    input logic             conflict,
    input logic [ROW_W-1:0] first_row
);

    AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        row_take && row_last |=> res_valid); // R8

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8

    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        conflict && !cfg_take |=> conflict); // R7

    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        conflict && !cfg_take |=> $stable(first_row)); // R7

    AST_FIRST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !conflict |-> first_row == '0); // R7

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_take |=> !conflict && first_row == '0); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_take |-> !row_take); // R6

endmodule

bind ternary_compat_checker tcc_sva #(.ROW_W(ROW_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_take  (cfg_take),
    .row_take  (row_take),
    .row_last  (row_last),
    .res_valid (res_valid),
    .conflict  (conflict),
    .first_row (first_row)
);

// File: tb/tb_ternary_compat_checker.sv
module tb_ternary_compat_checker;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 6;
    localparam int RW  = 4;
    localparam int IW  = 3;
    localparam logic [1:0] T0 = 2'b00, T1 = 2'b01, TX = 2'b10, TY = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [NC-1:0] cfg_mask = '0;
    logic [IW-1:0] cfg_col_a = '0, cfg_col_b = '0, cfg_col_c = '0;
    logic [3:0]    cfg_func = '0;
    logic          row_valid = 1'b0, row_last = 1'b0;
    logic [2*NC-1:0] row_data = '0;
    logic          res_valid, conflict;
    logic [RW-1:0] first_row;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ternary_compat_checker #(.NUM_COLS(NC), .ROW_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_mask(cfg_mask), .cfg_col_a(cfg_col_a), .cfg_col_b(cfg_col_b),
        .cfg_col_c(cfg_col_c), .cfg_func(cfg_func), .row_valid(row_valid),
        .row_last(row_last), .row_data(row_data), .res_valid(res_valid),
        .conflict(conflict), .first_row(first_row)
    );

    // ---------------- behavioural reference model ----------------
    bit m_open, m_conf, m_resv;
    int m_first, m_cnt;
    int m_mode, m_a, m_b, m_c, m_f;
    bit [NC-1:0] m_mask;

    function automatic int val(input logic [2*NC-1:0] d, input int col);
        // -1 for don't-care, else 0/1
        if (d[2*col+1]) return -1;
        return int'(d[2*col]);
    endfunction

    function automatic bit fn(input int code, input bit a, input bit b);
        case (code)
            0: return a & b;
            1: return ~(a & b);
            2: return a | b;
            3: return ~(a | b);
            4: return a ^ b;
            5: return ~(a ^ b);
            6: return a & ~b;
            7: return ~a & b;
            8: return a | ~b;
            default: return ~a | b;
        endcase
    endfunction

    function automatic bit cfg_ok(input int mode, input int a, input int b, input int c, input int f);
        if (mode == 3) return 0;
        if (mode == 1) return (a < NC) && (b < NC);
        if (mode == 2) return (a < NC) && (b < NC) && (c < NC) && (f < 10);
        return 1;
    endfunction

    function automatic bit model_clash(input logic [2*NC-1:0] d);
        int zeros = 0, ones = 0;
        if (m_mode == 0) begin
            for (int i = 0; i < NC; i++) begin
                if (m_mask[i] && val(d, i) == 0) zeros++;
                if (m_mask[i] && val(d, i) == 1) ones++;
            end
            return (zeros > 0) && (ones > 0);
        end else if (m_mode == 1) begin
            return (val(d, m_a) >= 0) && (val(d, m_b) >= 0) && (val(d, m_a) == val(d, m_b));
        end else begin
            if (val(d, m_c) < 0) return 0;
            for (int x = 0; x < 2; x++)
                for (int y = 0; y < 2; y++)
                    if ((val(d, m_a) < 0 || val(d, m_a) == x) &&
                        (val(d, m_b) < 0 || val(d, m_b) == y) &&
                        int'(fn(m_f, x[0], y[0])) == val(d, m_c))
                        return 0;
            return 1;
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_open <= 0; m_conf <= 0; m_resv <= 0; m_first <= 0; m_cnt <= 0;
            m_mode <= 0; m_a <= 0; m_b <= 0; m_c <= 0; m_f <= 0; m_mask <= '0;
        end else if (cfg_load && cfg_ok(int'(cfg_mode), int'(cfg_col_a), int'(cfg_col_b),
                                        int'(cfg_col_c), int'(cfg_func))) begin
            m_open <= 1; m_conf <= 0; m_resv <= 0; m_first <= 0; m_cnt <= 0;
            m_mode <= int'(cfg_mode); m_a <= int'(cfg_col_a); m_b <= int'(cfg_col_b);
            m_c <= int'(cfg_col_c); m_f <= int'(cfg_func); m_mask <= cfg_mask;
        end else begin
            m_resv <= 0;
            if (m_open && row_valid) begin
                if (model_clash(row_data) && !m_conf) begin
                    m_conf <= 1; m_first <= m_cnt;
                end
                if (m_cnt < (1 << RW) - 1) m_cnt <= m_cnt + 1;
                if (row_last) begin m_open <= 0; m_resv <= 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (res_valid !== m_resv || conflict !== m_conf || int'(first_row) != m_first) begin
                errors++;
                $display("FAIL R7/R8 model compare: res_valid=%0b conflict=%0b first_row=%0d expected %0b %0b %0d",
                         res_valid, conflict, first_row, m_resv, m_conf, m_first);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [2*NC-1:0] mk(input logic [1:0] c0, c1, c2, c3, c4, c5);
        return {c5, c4, c3, c2, c1, c0};
    endfunction

    task automatic load(input int mode, input logic [NC-1:0] mask, input int a, input int b,
                        input int c, input int f);
        cfg_load = 1; cfg_mode = mode[1:0]; cfg_mask = mask;
        cfg_col_a = a[IW-1:0]; cfg_col_b = b[IW-1:0]; cfg_col_c = c[IW-1:0]; cfg_func = f[3:0];
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic beat(input logic [2*NC-1:0] d, input bit last);
        row_data = d; row_valid = 1; row_last = last;
        @(negedge clk);
        row_valid = 0; row_last = 0;
    endtask

    // document-style matrix, columns 0..3
    logic [2*NC-1:0] mat [5];

    task automatic send_mat();
        for (int r = 0; r < 5; r++) beat(mat[r], r == 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mat[0] = mk(TX, T1, T0, T1, TX, TX);
        mat[1] = mk(T1, T0, T1, T1, TX, TX);
        mat[2] = mk(T0, T0, T0, T0, TX, TX);
        mat[3] = mk(T1, T1, TX, T0, TX, TX);
        mat[4] = mk(TX, T0, TX, TX, TX, TX);

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state, rows ignored before any load
        chk(conflict == 0 && first_row == 0 && res_valid == 0, "R9 reset outputs", int'(conflict), 0);
        beat(mk(T0, T1, T0, T1, T0, T1), 1);
        beat(mk(T0, T0, T0, T0, T0, T0), 1);
        chk(res_valid == 0 && conflict == 0, "R9 rows ignored before load", int'(res_valid), 0);

        // R2 R1: direct columns 0 and 2 pass
        load(0, 6'b000101, 0, 0, 0, 0);
        send_mat();
        chk(res_valid == 1, "R8 result pulse after last", int'(res_valid), 1);
        chk(conflict == 0, "R2 R1 direct cols 0,2 compatible", int'(conflict), 0);
        @(negedge clk);
        chk(res_valid == 0, "R8 result pulse one cycle", int'(res_valid), 0);

        // R2: direct columns 0 and 1 fail on row 1
        load(0, 6'b000011, 0, 0, 0, 0);
        beat(mat[0], 0);
        beat(mat[1], 0);
        chk(conflict == 1 && first_row == 1, "R11 conflict visible next cycle", int'(first_row), 1);
        beat(mat[2], 0); beat(mat[3], 0); beat(mat[4], 1);
        chk(conflict == 1 && first_row == 1, "R2 direct cols 0,1 first conflict", int'(first_row), 1);

        // R3 R7: inverse 0,1 -> rows 2 and 3 clash, first stays 2
        load(1, '0, 0, 1, 0, 0);
        chk(conflict == 0 && first_row == 0, "R6 load clears verdict", int'(conflict), 0);
        send_mat();
        chk(conflict == 1 && first_row == 2, "R3 R7 inverse first conflict kept", int'(first_row), 2);

        // R5: refused loads leave closed stream and verdict untouched
        load(3, '0, 0, 1, 2, 0);
        load(2, '0, 0, 1, 2, 10);
        load(1, '0, 6, 1, 0, 0);
        load(2, '0, 0, 1, 7, 0);
        chk(conflict == 1 && first_row == 2, "R5 refused loads keep verdict", int'(first_row), 2);
        beat(mk(T0, T0, T0, T0, T0, T0), 1);
        chk(res_valid == 0, "R5 R8 rows still ignored", int'(res_valid), 0);

        // R5: direct load ignores out-of-range column fields
        load(0, 6'b110000, 7, 7, 7, 15);
        chk(conflict == 0 && first_row == 0, "R5 direct load accepted", int'(conflict), 0);
        beat(mk(TX, TX, TX, TX, T0, T1), 0);
        // refused load inside an open stream: keeps numbering and verdict
        load(2, '0, 6, 0, 0, 0);
        beat(mk(TX, TX, TX, TX, T1, T0), 1);
        chk(conflict == 1 && first_row == 0, "R5 refused load mid-stream", int'(first_row), 0);

        // R4: AND gate, b don't-care
        load(2, '0, 0, 1, 2, 0);
        beat(mk(T0, TX, T1, TX, TX, TX), 1);
        chk(conflict == 1 && first_row == 0, "R4 AND a=0 b=X t=1 clash", int'(conflict), 1);
        load(2, '0, 0, 1, 2, 0);
        beat(mk(T1, TY, T1, TX, TX, TX), 0);
        beat(mk(TX, TX, T0, TX, TX, TX), 0);
        beat(mk(T0, T1, TY, TX, TX, TX), 1);
        chk(conflict == 0, "R4 R1 AND reachable targets", int'(conflict), 0);
        // XOR
        load(2, '0, 0, 1, 2, 4);
        beat(mk(TX, T0, T1, TX, TX, TX), 0);
        beat(mk(T1, T1, T1, TX, TX, TX), 1);
        chk(conflict == 1 && first_row == 1, "R4 XOR clash on row 1", int'(first_row), 1);

        // R6: load wins over same-cycle row beat
        load(1, '0, 0, 1, 0, 0);
        cfg_load = 1; cfg_mode = 2'b01; cfg_col_a = 3'd2; cfg_col_b = 3'd3;
        row_valid = 1; row_last = 1; row_data = mk(TX, TX, T1, T1, TX, TX);
        @(negedge clk);
        cfg_load = 0; row_valid = 0; row_last = 0;
        chk(conflict == 0 && res_valid == 0, "R6 row dropped under load", int'(conflict), 0);
        beat(mk(TX, TX, T0, T1, TX, TX), 1);
        chk(conflict == 0 && res_valid == 1, "R6 stream still open after drop", int'(res_valid), 1);

        // R10: saturation with 4-bit index
        load(0, 6'b000011, 0, 0, 0, 0);
        for (int r = 0; r < 20; r++)
            beat((r == 18) ? mk(T0, T1, TX, TX, TX, TX) : mk(T0, T0, TX, TX, TX, TX), r == 19);
        chk(conflict == 1 && first_row == 15, "R10 saturated index", int'(first_row), 15);

        // R4 sweep all gate functions with random rows
        for (int f = 0; f < 10; f++) begin
            load(2, '0, 1, 3, 5, f);
            for (int r = 0; r < 12; r++) begin
                logic [2*NC-1:0] d;
                d = 12'($urandom);
                beat(d, r == 11);
            end
        end
        // random direct/inverse streams
        for (int t = 0; t < 20; t++) begin
            load(t % 2, 6'($urandom), int'($urandom % NC), int'($urandom % NC), 0, 0);
            for (int r = 0; r < 8; r++) beat(12'($urandom), r == 7);
        end

        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule